// File: doc/BRIEF.md
# Pipelined SPI Command Register Decoder

This block is the peripheral end of a 16-bit SPI command link for a multi-channel load-driver controller. Each chip-select window carries one 16-bit command word, sent MSB first. The top nibble is the opcode. Ten write opcodes load masked configuration fields. One read opcode picks any of sixteen registers. A check opcode arms a fixed acknowledge pattern.

The answer to a command is not returned in the same window. It is queued and shifted out during the next window. Every configuration write queues the all-status summary automatically, and so does a read of index 0. The summary is built from four sticky fault registers that are fed by plain input ports. Each fault register clears when it is read and then reloads at once from the live fault inputs.

SCK, chip select and MOSI are oversampled in the system clock domain. A frame whose length is anything other than sixteen SCK pulses is thrown away. The block then flags the error in the next summary word.

Top module: `spi_cmd_regfile`

## Requirements
- R1: A frame is kept only if it has exactly 16 rising SCK edges between the chip-select fall and rise. A shorter or longer frame leaves the queued reply, the configuration and the fault registers unchanged. It also sets bit 14 of the next all-status word, and bit 14 clears once that word has been queued.
- R2: A frame whose bits 15:12 are 0x0 and whose bits 11:8 are 0xA is a read. Bits 7:4 give the register index, and the selected word is shifted out during the following frame.
- R3: Opcodes 0x1 to 0xA store the low 12 bits of the frame, and index 4+opcode reads them back zero-extended. Opcode 0x1 maps to index 5 and opcode 0xA maps to index 14.
- R4: Three opcodes mask their payload before it is stored. Opcode 0x3 keeps bits 7:0, opcode 0x5 keeps bits 1:0, and opcode 0x9 keeps the bits set in 0x0F0F.
- R5: After any opcode 0x1 to 0xA, and after a read of index 0, the next frame returns the all-status word.
- R6: Index 15 returns 0x0D0A when the frame just before the read was exactly 0x0F00. Otherwise it returns the REV_ID parameter.
- R7: The all-status word is built as follows. Bit k (k=0..3) is the OR of nibble k of the 16-bit word {out23, out01}. Bit 4+k is the OR of bits 3k+2:3k of the gate fault register. Bit 8+k is the OR of bits 3k+2:3k of the ignition fault register. Bit 14 is the framing flag, and all other bits are 0.
- R8: Fault registers 1 to 4 are 8, 8, 12 and 12 bits wide and accumulate their inputs stickily. A read returns the held value and reloads the register from the live inputs.
- R9: After reset all configuration fields are zero and the first reply word is 0x4000.
- R10: Opcode 0xE, opcode 0x0 that is not a read, and the unused opcodes 0xB to 0xF store nothing and queue a reply of 0x0000.
- R11: MOSI is sampled on the rising SCK edge and MISO advances on the falling edge, MSB first. The first bit is valid from the chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial command in |
| miso | output | 1 | Serial reply out |
| flt_out01 | input | 8 | Live faults for low-side outputs 0 and 1 (nibble each) |
| flt_out23 | input | 8 | Live faults for low-side outputs 2 and 3 |
| flt_gate | input | 12 | Live gate-driver faults, 3 bits per channel |
| flt_ign | input | 12 | Live ignition faults, 3 bits per channel |

## Verification
A reply is due one whole frame after the command that requested it. Every check therefore compares the word captured in frame N with the value predicted from the command of frame N-1. MISO is resynchronised and shifted about three system clocks after each falling SCK edge. The bench holds each SCK phase for six clocks and samples MISO just before the next rising edge. After chip-select rises the bench idles eight clocks so that the decode and the fault clear have completed before the next frame starts. Fault inputs are changed only between frames, so the summary snapshot taken at frame end is predictable.

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile #(
  parameter logic [15:0] REV_ID = 16'h00A3,
  parameter int SYNC = 2,
  parameter int NCFG = 10,
  parameter int CFGW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  input  logic [7:0]  flt_out01,
  input  logic [7:0]  flt_out23,
  input  logic [11:0] flt_gate,
  input  logic [11:0] flt_ign
);
  localparam int FLEN = 16;
  localparam int CW   = $clog2(FLEN + 2);
  localparam logic [CW-1:0] CMAX = CW'(FLEN + 1);
  localparam logic [15:0] ACK_WORD = 16'h0D0A;
  localparam logic [15:0] CHK_CMD  = 16'h0F00;

  logic [SYNC:0] sck_p, cs_p, mosi_p;
  logic [CW-1:0] cnt_q;
  logic [15:0]   rx_q, sh_q, reply_q, stat, rd_word, nxt;
  logic          chk_q, com_q;
  logic [NCFG-1:0][CFGW-1:0] cfg_q;
  logic [7:0]    f1_q, f2_q;
  logic [11:0]   f3_q, f4_q;
  logic [3:0]    s_out, s_gd, s_ign;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC-1:0], sck};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      mosi_p <= {mosi_p[SYNC-1:0], mosi};
    end

  wire sel    = ~cs_p[SYNC-1];
  wire sck_re = sel & sck_p[SYNC-1] & ~sck_p[SYNC];
  wire sck_fe = sel & ~sck_p[SYNC-1] & sck_p[SYNC];
  wire cs_fe  = ~cs_p[SYNC-1] & cs_p[SYNC];
  wire cs_re  = cs_p[SYNC-1] & ~cs_p[SYNC];
  wire good   = cs_re & (cnt_q == CW'(FLEN));
  wire bad    = cs_re & (cnt_q != CW'(FLEN));

  wire [3:0] cmd   = rx_q[15:12];
  wire [3:0] idx   = rx_q[7:4];
  wire       is_wr = (cmd >= 4'h1) && (cmd <= 4'hA);
  wire       is_rd = (cmd == 4'h0) && (rx_q[11:8] == 4'hA);
  wire       q_stat = is_wr || (is_rd && idx == 4'h0);

  assign miso = sh_q[15];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      s_gd[k]  = |f3_q[3*k +: 3];
      s_ign[k] = |f4_q[3*k +: 3];
    end
    s_out = {|f2_q[7:4], |f2_q[3:0], |f1_q[7:4], |f1_q[3:0]};
  end
  assign stat = {1'b0, com_q, 2'b00, s_ign, s_gd, s_out};

  always_comb begin
    rd_word = 16'h0000;
    case (idx)
      4'h0: rd_word = stat;
      4'h1: rd_word = {8'h00, f1_q};
      4'h2: rd_word = {8'h00, f2_q};
      4'h3: rd_word = {4'h0, f3_q};
      4'h4: rd_word = {4'h0, f4_q};
      4'hF: rd_word = chk_q ? ACK_WORD : REV_ID;
      default:
        for (int k = 0; k < NCFG; k++)
          if (idx == 4'(k + 5)) rd_word = 16'(cfg_q[k]);
    endcase
  end

  always_comb begin
    if (q_stat)     nxt = stat;
    else if (is_rd) nxt = rd_word;
    else            nxt = 16'h0000;
  end

  function automatic logic [CFGW-1:0] wmask(input logic [3:0] c);
    case (c)
      4'h3:    wmask = CFGW'(12'h0FF);
      4'h5:    wmask = CFGW'(12'h003);
      4'h9:    wmask = CFGW'(12'hF0F);
      default: wmask = '1;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      sh_q  <= 16'h4000;
    end else begin
      if (cs_fe) begin
        cnt_q <= '0;
        sh_q  <= reply_q;
      end else begin
        if (sck_re) begin
          cnt_q <= (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
          rx_q  <= {rx_q[14:0], mosi_p[SYNC-1]};
        end
        if (sck_fe) sh_q <= {sh_q[14:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reply_q <= 16'h4000;
      chk_q   <= 1'b0;
      com_q   <= 1'b0;
      cfg_q   <= '0;
    end else if (good) begin
      reply_q <= nxt;
      chk_q   <= (rx_q == CHK_CMD);
      if (q_stat) com_q <= 1'b0;
      for (int k = 0; k < NCFG; k++)
        if (is_wr && cmd == 4'(k + 1)) cfg_q[k] <= rx_q[CFGW-1:0] & wmask(cmd);
    end else if (bad) begin
      com_q <= 1'b1;
    end

  wire clr1 = good & is_rd & (idx == 4'h1);
  wire clr2 = good & is_rd & (idx == 4'h2);
  wire clr3 = good & is_rd & (idx == 4'h3);
  wire clr4 = good & is_rd & (idx == 4'h4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f1_q <= '0;
      f2_q <= '0;
      f3_q <= '0;
      f4_q <= '0;
    end else begin
      f1_q <= clr1 ? flt_out01 : (f1_q | flt_out01);
      f2_q <= clr2 ? flt_out23 : (f2_q | flt_out23);
      f3_q <= clr3 ? flt_gate  : (f3_q | flt_gate);
      f4_q <= clr4 ? flt_ign   : (f4_q | flt_ign);
    end

  p_bad_keeps_reply_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> ($stable(reply_q) && com_q));
  p_cfg_only_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(good && is_wr) |=> $stable(cfg_q));
  p_status_queued_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (good && is_wr) |=> (reply_q == $past(stat)) && !com_q);
  p_fault_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr1 |=> (f1_q == $past(flt_out01)) && (reply_q[7:0] == $past(f1_q)));
  p_cnt_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  p_shift_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fe && !cs_fe) |=> sh_q[15] == $past(sh_q[14]));
endmodule

// File: tb/spi_cmd_regfile_tb.sv
`timescale 1ns/1ps
module spi_cmd_regfile_tb_top;
  localparam logic [15:0] REV = 16'h00A3;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0]  flt_out01 = '0, flt_out23 = '0;
  logic [11:0] flt_gate = '0, flt_ign = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cmd_regfile #(.REV_ID(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .flt_out01(flt_out01), .flt_out23(flt_out23), .flt_gate(flt_gate), .flt_ign(flt_ign)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, input int nb, output logic [15:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 16) ? tx[15 - i] : 1'b1;
      wclk(6);
      rx = {rx[14:0], miso};
      sck = 1'b1;
      wclk(6);
      sck = 1'b0;
    end
    wclk(6);
    cs_n = 1'b1;
    wclk(8);
  endtask

  task automatic send(input logic [15:0] tx, input logic [15:0] exp, input string tag);
    logic [15:0] rx;
    xfer(tx, 16, rx);
    check(tag, rx, exp);
  endtask

  task automatic t_reset;
    check("R9 idle miso", {15'h0, miso}, 16'h0000);
    send(16'h0A50, 16'h4000, "R9 first reply");
    send(16'h0A00, 16'h0000, "R9 cfg zero / R2 read idx5");
  endtask

  task automatic t_write_read;
    send(16'h1ABC, 16'h0000, "R5 status after read0");
    send(16'h0A50, 16'h0000, "R5 status after write");
    send(16'h2123, 16'h0ABC, "R3 idx5");
    send(16'h0A60, 16'h0000, "R5 status");
    send(16'h0A00, 16'h0123, "R3 idx6");
  endtask

  task automatic t_masks;
    send(16'h3FFF, 16'h0000, "R5");
    send(16'h5FFF, 16'h0000, "R5");
    send(16'h9FFF, 16'h0000, "R5");
    send(16'hAFFF, 16'h0000, "R5");
    send(16'h0A70, 16'h0000, "R5");
    send(16'h0A90, 16'h00FF, "R4 op3 mask");
    send(16'h0AD0, 16'h0003, "R4 op5 mask");
    send(16'h0AE0, 16'h0F0F, "R4 op9 mask");
    send(16'h0A00, 16'h0FFF, "R3 opA full");
  endtask

  task automatic t_check_cmd;
    send(16'h0AF0, 16'h0000, "R5");
    send(16'h0F00, REV,      "R6 revision");
    send(16'h0AF0, 16'h0000, "R10 check cmd reply");
    send(16'h0A00, 16'h0D0A, "R6 acknowledge");
    send(16'h0AF0, 16'h0000, "R5");
    send(16'h0A00, REV,      "R6 ack only once");
  endtask

  task automatic t_faults;
    flt_out01 = 8'h10; flt_gate = 12'h008; flt_ign = 12'h200;
    wclk(4);
    send(16'h0A00, 16'h0000, "R7 before faults");
    flt_out01 = '0; flt_gate = '0; flt_ign = '0;
    send(16'h0A10, 16'h0822, "R7 summary");
    send(16'h0A10, 16'h0010, "R8 sticky");
    flt_out01 = 8'h01;
    send(16'h0A30, 16'h0000, "R8 cleared on read");
    send(16'h0A40, 16'h0008, "R8 gate reg");
    send(16'h0A10, 16'h0200, "R8 ign reg");
    flt_out01 = 8'h00;
    send(16'h0A00, 16'h0001, "R8 reload from live");
    send(16'h0A00, 16'h0001, "R7 out0 bit");
  endtask

  task automatic t_framing;
    logic [15:0] rx;
    send(16'h0A50, 16'h0001, "R7");
    xfer(16'hFFFF, 8, rx);
    send(16'h0A00, 16'h0ABC, "R1 short frame ignored");
    send(16'h0000, 16'h4001, "R1 flag in status");
    send(16'h0A00, 16'h0000, "R10 op0 non-read");
    send(16'hE123, 16'h0001, "R1 flag cleared");
    send(16'h0A50, 16'h0000, "R10 calib reply");
    send(16'h0AE0, 16'h0ABC, "R10 calib stores nothing");
    xfer(16'h1555, 20, rx);
    send(16'h0000, 16'h0FFF, "R1 long frame ignored");
    send(16'h0A00, 16'h0000, "R10");
    send(16'h0000, 16'h4001, "R1 long frame flag / R11");
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset;
    t_write_read;
    t_masks;
    t_check_cmd;
    t_faults;
    t_framing;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule